// File: doc/BRIEF.md
# Peripheral Clock Select-Divide-Gate Unit

This block produces the tick enables for a pair of serial-port channels that share one clock source. Everything runs on a single system clock. Three incoming single-cycle tick strobes stand in for three PLL outputs. A 32-bit configuration word chooses one of those strobes and sets a divide ratio. Two enable bits in the same word then pass or block the divided ticks for each channel. The outputs are single-cycle enable pulses, not derived clocks.

Software writes the configuration word through a simple write strobe and data bus, and reads it back on a separate data bus. The source select field sits in bits 5:4 and the divide ratio in bits 13:8. Channel 0's enable is bit 0 and channel 1's enable is bit 1. Any other bit is held as written.

The divider is a two-state machine. DIV_PASS forwards every selected tick and is used when the divisor is 0 or 1. DIV_COUNT counts selected ticks and pulses on every Nth one. The transitions are:
- Reset leads to DIV_PASS.
- A write whose divisor field is 0 or 1 leads to DIV_PASS.
- A write whose divisor field is 2 or more leads to DIV_COUNT.
- With no write, the state does not change.

Top module: `perclk_gen`

## Requirements
- R1: `rd_data` returns the last word written, all 32 bits, including bits that no function uses. The new value is visible in the cycle after the write edge.
- R2: A synchronous reset (`rst` high at a clock edge) clears the configuration word to zero. That means select 00, divisor 0 and both channels off. While the word stays zero, `ch_tick` remains 0.
- R3: The select field is bits 5:4. Code 00 and code 01 both choose `src_tick[0]`. Code 10 chooses `src_tick[1]` and code 11 chooses `src_tick[2]`. Unselected strobes have no effect on the outputs.
- R4: The divisor N is bits 13:8. For N of 2 or more, a pulse is emitted on the Nth selected tick after a restart and on every Nth one after that. Over a run of T selected ticks after a write, an enabled channel therefore gives floor(T/N) pulses.
- R5: A divisor field of 0 or of 1 divides by one: every selected tick produces a pulse.
- R6: Bit 0 enables `ch_tick[0]` and bit 1 enables `ch_tick[1]`, each on its own. A channel whose bit is 0 never pulses.
- R7: Any write restarts the divide count from zero. Ticks present in the write cycle are dropped, and `ch_tick` is 0 in the cycle after the write edge.
- R8: A selected tick sampled at a clock edge produces its output pulse in the cycle after that edge. Each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to write |
| rd_data | output | 32 | Current configuration word |
| src_tick | input | 3 | Source tick strobes, one per source |
| ch_tick | output | 2 | Gated divided tick, one per channel |

## Verification
A write takes effect at its clock edge. The read-back value is due one cycle later, and in that same cycle both channel outputs must be low. A tick sampled at an edge yields its pulse in the following cycle. The bench therefore samples at each falling edge, so what it sees is the result of the previous rising edge. It counts pulses over exactly the window that mirrors the ticks it drove, then samples once more after the last drive. With this alignment, the expected pulse count for each select code, divisor and enable pattern is floor(ticks/N), worked out arithmetically.

// File: rtl/perclk_pkg.sv
package perclk_pkg;

    localparam int CFG_W      = 32;
    localparam int DIV_W      = 6;
    localparam int SEL_W      = 2;
    localparam int NUM_SRC    = 3;
    localparam int NUM_CH     = 2;

    localparam int GATE_LSB   = 0;
    localparam int SEL_LSB    = 4;
    localparam int DIV_LSB    = 8;

    typedef enum logic [0:0] {
        DIV_PASS  = 1'b0,
        DIV_COUNT = 1'b1
    } div_state_t;

endpackage

// File: rtl/perclk_cfg_reg.sv
module perclk_cfg_reg
    import perclk_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cfg_q,
    output logic         restart
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_data;
        end
    end

    assign restart = wr_en;

    // R1: the stored word matches the last write, bit for bit
    assert_readback_R1: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) && !$past(rst) |-> cfg_q == $past(wr_data));

endmodule

// File: rtl/perclk_src_sel.sv
module perclk_src_sel
    import perclk_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int SW   = SEL_W
) (
    input  logic [SW-1:0]   sel_code,
    input  logic [NSRC-1:0] src_tick,
    output logic            tick_sel
);

    always_comb begin
        unique case (sel_code)
            2'b00,
            2'b01:   tick_sel = src_tick[0];
            2'b10:   tick_sel = src_tick[1];
            default: tick_sel = src_tick[2];
        endcase
    end

endmodule

// File: rtl/perclk_div.sv
module perclk_div
    import perclk_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [DW-1:0] new_div,
    input  logic [DW-1:0] cur_div,
    input  logic          tick,
    output logic          pulse
);

    localparam logic [DW-1:0] ONE = DW'(1);

    div_state_t    state_q, state_d;
    logic [DW-1:0] cnt_q, cnt_d;
    logic          pulse_q, pulse_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_PASS;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pulse_q <= pulse_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pulse_d = 1'b0;
        if (restart) begin
            state_d = (new_div <= ONE) ? DIV_PASS : DIV_COUNT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                DIV_PASS: begin
                    pulse_d = tick;
                end
                DIV_COUNT: begin
                    if (tick) begin
                        if (cnt_q == cur_div - ONE) begin
                            cnt_d   = '0;
                            pulse_d = 1'b1;
                        end else begin
                            cnt_d   = cnt_q + ONE;
                        end
                    end
                end
                default: begin
                    state_d = DIV_PASS;
                end
            endcase
        end
    end

    assign pulse = pulse_q;

    // R8: a pulse is always the result of a selected tick at the previous edge
    assert_pulse_from_tick_R8: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(tick));

    // R7: the cycle after a write never carries a pulse
    assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> !pulse_q);

    // R4: the count never reaches the divisor
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        state_q == DIV_COUNT |-> cnt_q < cur_div);

endmodule

// File: rtl/perclk_gen.sv
module perclk_gen
    import perclk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CFG_W-1:0]    wr_data,
    output logic [CFG_W-1:0]    rd_data,
    input  logic [NUM_SRC-1:0]  src_tick,
    output logic [NUM_CH-1:0]   ch_tick
);

    logic [CFG_W-1:0] cfg_q;
    logic             restart;
    logic             tick_sel;
    logic             div_pulse;

    perclk_cfg_reg #(.W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .restart (restart)
    );

    perclk_src_sel #(.NSRC(NUM_SRC), .SW(SEL_W)) u_sel (
        .sel_code (cfg_q[SEL_LSB +: SEL_W]),
        .src_tick (src_tick),
        .tick_sel (tick_sel)
    );

    perclk_div #(.DW(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .new_div (wr_data[DIV_LSB +: DIV_W]),
        .cur_div (cfg_q[DIV_LSB +: DIV_W]),
        .tick    (tick_sel),
        .pulse   (div_pulse)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_gate
        assign ch_tick[c] = div_pulse & cfg_q[GATE_LSB + c];
    end

    assign rd_data = cfg_q;

    // R2: one cycle after reset the word is clear and outputs are silent
    assert_reset_clear_R2: assert property (@(posedge clk)
        $past(rst) |-> (rd_data == '0) && (ch_tick == '0));

endmodule

// File: tb/perclk_gen_tb.sv
module perclk_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  src_tick = '0;
    logic [1:0]  ch_tick;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wd     = 0;
    bit done   = 1'b0;

    localparam int WIN = 200;

    always #4 clk = ~clk;

    perclk_gen u_dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .src_tick (src_tick),
        .ch_tick  (ch_tick)
    );

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 190000 && !done) begin
            done = 1'b1;
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // source s ticks once every s+1 cycles
    task automatic drive_ticks();
        cyc++;
        for (int s = 0; s < 3; s++) src_tick[s] = ((cyc % (s + 1)) == 0);
    endtask

    task automatic run_cfg(input int code, input int dv, input int gates, input int tag);
        logic [31:0] w;
        int src, ntk, p0, p1, deff;
        w = {tag[17:0], dv[5:0], tag[1:0], code[1:0], tag[3:2], gates[1:0]};
        src = (code < 2) ? 0 : code - 1;            // R3 mapping
        deff = (dv == 0) ? 1 : dv;                  // R5
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        src_tick = 3'b111;                          // dropped by the write (R7)
        @(negedge clk);
        wr_en = 1'b0;
        chk("R1 readback", rd_data, w);
        chk("R7 quiet after write", ch_tick, 0);
        ntk = 0; p0 = 0; p1 = 0;
        for (int j = 0; j < WIN; j++) begin
            p0 += ch_tick[0];
            p1 += ch_tick[1];
            drive_ticks();
            ntk += src_tick[src];
            @(negedge clk);
        end
        p0 += ch_tick[0];
        p1 += ch_tick[1];
        src_tick = '0;
        // R4 R6 R8: floor(ticks/N) on enabled channels, none on disabled
        chk($sformatf("R4 R6 ch0 code=%0d div=%0d", code, dv), p0, gates[0] ? ntk / deff : 0);
        chk($sformatf("R4 R6 ch1 code=%0d div=%0d", code, dv), p1, gates[1] ? ntk / deff : 0);
    endtask

    initial begin
        int divs [9] = '{0, 1, 2, 3, 4, 5, 7, 13, 63};
        int tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset word", rd_data, 0);
        chk("R2 reset outputs", ch_tick, 0);

        tag = 1;
        for (int c = 0; c < 4; c++)
            for (int d = 0; d < 9; d++)
                for (int g = 0; g < 4; g++) begin
                    run_cfg(c, divs[d], g, tag * 32'h9E37);
                    tag++;
                end

        // R2: reset in the middle of operation, ticks keep running
        run_cfg(0, 0, 3, 32'h5A5A);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R2 word after reset", rd_data, 0);
        for (int j = 0; j < 20; j++) begin
            drive_ticks();
            @(negedge clk);
            chk("R2 outputs off after reset", ch_tick, 0);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule